// File: doc/BRIEF.md
# SPI boot memory address-width detector

This block is a small SPI master that runs once per start pulse, normally straight after reset. It finds out what kind of serial boot memory sits on the bus and then fetches the first ten bytes of the boot image from address zero. It issues a series of short read commands of growing length. Each command is a read opcode, then one, two or three zero address bytes, then one extra byte clocked in as the reply. The first command that brings back something other than the idle-high value 0xFF fixes the address width. If none of them does, the block sends a status-register read to test for a page-organised flash. If that reply is also 0xFF, it raises an error and stops.

Once the type is known, chip select is released and driven low again for a new read command. The address is all zeros at the detected width; the flash type uses a fast-read command with a dummy byte instead. The next ten reply bytes leave on a valid/ready byte stream. A byte stays on `hdr_data` with `hdr_valid` high until it is accepted. While a byte waits, the serial clock is held, so a slow consumer costs time but never data. Making sense of the header and loading the rest of the image are left to the logic downstream.

Top module: `spi_boot_probe`

## Requirements
- R1: After reset `cs_n` is 1, `sck` is 0, `hdr_valid` is 0, `done` is 0, `error` is 0 and `mem_type` is 0.
- R2: SPI mode 0, most significant bit first. `sck` idles low and stays low whenever `cs_n` is high. Each high phase and each low phase of `sck` lasts `clk_div` clock cycles, and a `clk_div` of 0 acts as 1. The serial rate is therefore clk / (2 x `clk_div`).
- R3: Probe attempts run in the order 8, 16, 24 bits. Attempt n (n = 1, 2, 3) is its own chip-select frame. It sends opcode 0x03, then n bytes of 0x00, then one more byte whose reply is captured. `cs_n` goes high between frames.
- R4: `mem_type` encodes 0 = unknown, 1 = 8-bit address, 2 = 16-bit, 3 = 24-bit, 4 = page-organised flash. A width is taken from the first attempt whose captured reply is not 0xFF.
- R5: If all three width attempts reply 0xFF, a fourth frame sends status opcode 0xD7 and one more byte. A reply other than 0xFF sets `mem_type` to 4.
- R6: If the status reply is also 0xFF, `error` goes to 1 and stays there. `mem_type` stays 0, `cs_n` stays 1 and no header byte is produced.
- R7: After detection, one more frame sends the read command. For widths 1 to 3 this is opcode 0x03 followed by `mem_type` zero bytes. For type 4 it is opcode 0x0B, three zero bytes and one dummy byte. The next 10 reply bytes come out on `hdr_data`, in address order starting at 0.
- R8: While `hdr_valid` is 1 and `hdr_ready` is 0, `hdr_valid` and `hdr_data` hold their values and `sck` does not toggle. A byte is accepted in a cycle where both `hdr_valid` and `hdr_ready` are 1.
- R9: `done` goes to 1 once the tenth header byte is accepted, with `cs_n` returned to 1. The header frame totals 11 + `mem_type` bytes for widths 1 to 3 and 15 bytes for type 4.
- R10: A `start` pulse while a run is in progress is ignored. A `start` pulse after `done` or `error` clears both flags and runs the full probe again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | 8 | Serial clock half-period in system clocks |
| start | input | 1 | One-cycle pulse that begins a detection run |
| sck | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the memory |
| miso | input | 1 | Serial data from the memory, idle high |
| mem_type | output | 3 | Detected memory type (R4 encoding) |
| hdr_valid | output | 1 | Header byte on `hdr_data` is valid |
| hdr_ready | input | 1 | Consumer accepts the header byte |
| hdr_data | output | 8 | Header byte |
| done | output | 1 | Header fully delivered |
| error | output | 1 | No memory type could be identified |

## Verification
The bench models each memory kind at bit level. For every run it checks the number of chip-select frames, the opcode and byte count of the last frame, and all ten header bytes against a scoreboard. A design that stops one attempt early or late, or sends one address byte too many, shows up as the wrong `mem_type`, the wrong frame count, or a header shifted by one address. Runs with a random `hdr_ready` check that a stalled byte keeps `sck` still; a design that keeps clocking while stalled loses or repeats bytes. Further runs cover a divisor of zero, a memory that never answers (error with no stream), a stray `start` in the middle of a run, and a restart after an error.

// File: rtl/spi_probe_pkg.sv
`timescale 1ns/1ps
package spi_probe_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    MT_NONE  = 3'd0,
    MT_A8    = 3'd1,
    MT_A16   = 3'd2,
    MT_A24   = 3'd3,
    MT_PAGED = 3'd4
  } mem_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_GAP, S_PROBE, S_READ, S_STREAM, S_HOLD, S_DONE, S_FAIL
  } seq_state_e;

  localparam logic [BYTE_W-1:0] OP_READ   = 8'h03;
  localparam logic [BYTE_W-1:0] OP_STATUS = 8'hD7;
  localparam logic [BYTE_W-1:0] OP_FAST   = 8'h0B;
  localparam logic [BYTE_W-1:0] NO_DATA   = 8'hFF;
endpackage

// File: rtl/spi_byte_engine.sv
`timescale 1ns/1ps
// One SPI mode-0 byte exchange per go pulse, MSB first.
module spi_byte_engine
  import spi_probe_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              go,
  input  logic [BYTE_W-1:0] tx,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              done,
  output logic [BYTE_W-1:0] rx
);
  localparam int BIT_W = $clog2(BYTE_W);

  logic [DIV_W-1:0]  cnt;
  logic [DIV_W-1:0]  lim;
  logic [BIT_W-1:0]  bitn;
  logic [BYTE_W-1:0] sh;
  logic              busy;

  assign lim  = (div == '0) ? '0 : div - 1'b1;
  assign mosi = sh[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
      rx   <= '0;
      sck  <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy <= 1'b1;
          sh   <= tx;
          cnt  <= '0;
          bitn <= '0;
        end
      end else if (cnt != lim) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        if (!sck) begin
          sck <= 1'b1;
          rx  <= {rx[BYTE_W-2:0], miso};
        end else begin
          sck <= 1'b0;
          if (bitn == BIT_W'(BYTE_W-1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitn <= bitn + 1'b1;
            sh   <= {sh[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/hdr_out_reg.sv
`timescale 1ns/1ps
// Single-entry valid/ready holding register for header bytes.
module hdr_out_reg
  import spi_probe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  input  logic              ready,
  output logic              valid,
  output logic [BYTE_W-1:0] data,
  output logic              accept
);
  assign accept = valid && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= din;
    end else if (accept) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_probe_seq.sv
`timescale 1ns/1ps
// Frame sequencer: width probes, status probe, header read.
module spi_probe_seq
  import spi_probe_pkg::*;
#(
  parameter int HDR_LEN = 10,
  parameter int GAP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              eng_done,
  input  logic [BYTE_W-1:0] eng_rx,
  input  logic              accept,
  output logic              go,
  output logic [BYTE_W-1:0] tx,
  output logic              cs_n,
  output logic              load,
  output mem_kind_e         kind,
  output logic              done,
  output logic              error
);
  localparam int HC_W  = $clog2(HDR_LEN);
  localparam int GAP_W = $clog2(GAP_CYC + 1);

  seq_state_e       state;
  logic [1:0]       att;
  logic [2:0]       idx;
  logic [HC_W-1:0]  hcnt;
  logic [GAP_W-1:0] gcnt;
  logic [2:0]       probe_last;
  logic [2:0]       cmd_last;
  logic             can_start;

  assign probe_last = (att == 2'd3) ? 3'd1 : {1'b0, att} + 3'd2;
  assign cmd_last   = (kind == MT_PAGED) ? 3'd4 : 3'(kind);
  assign can_start  = (state == S_IDLE) || (state == S_DONE) || (state == S_FAIL);

  always_comb begin
    tx = '0;
    if (idx == 3'd0) begin
      if (state == S_PROBE)     tx = (att == 2'd3) ? OP_STATUS : OP_READ;
      else if (state == S_READ) tx = (kind == MT_PAGED) ? OP_FAST : OP_READ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      att   <= '0;
      idx   <= '0;
      hcnt  <= '0;
      gcnt  <= '0;
      kind  <= MT_NONE;
      go    <= 1'b0;
      load  <= 1'b0;
      cs_n  <= 1'b1;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      go   <= 1'b0;
      load <= 1'b0;
      if (start && can_start) begin
        state <= S_GAP;
        att   <= '0;
        gcnt  <= '0;
        kind  <= MT_NONE;
        done  <= 1'b0;
        error <= 1'b0;
      end else begin
        case (state)
          S_GAP: begin
            if (gcnt == GAP_W'(GAP_CYC - 1)) begin
              state <= (kind == MT_NONE) ? S_PROBE : S_READ;
              idx   <= '0;
              cs_n  <= 1'b0;
              go    <= 1'b1;
            end else begin
              gcnt <= gcnt + 1'b1;
            end
          end
          S_PROBE: begin
            if (eng_done) begin
              if (idx == probe_last) begin
                cs_n <= 1'b1;
                gcnt <= '0;
                if (eng_rx != NO_DATA) begin
                  kind  <= (att == 2'd3) ? MT_PAGED
                                         : mem_kind_e'({1'b0, att} + 3'd1);
                  state <= S_GAP;
                end else if (att == 2'd3) begin
                  state <= S_FAIL;
                  error <= 1'b1;
                end else begin
                  att   <= att + 1'b1;
                  state <= S_GAP;
                end
              end else begin
                idx <= idx + 1'b1;
                go  <= 1'b1;
              end
            end
          end
          S_READ: begin
            if (eng_done) begin
              if (idx == cmd_last) begin
                state <= S_STREAM;
                hcnt  <= '0;
              end else begin
                idx <= idx + 1'b1;
              end
              go <= 1'b1;
            end
          end
          S_STREAM: begin
            if (eng_done) begin
              load  <= 1'b1;
              state <= S_HOLD;
            end
          end
          S_HOLD: begin
            if (accept) begin
              if (hcnt == HC_W'(HDR_LEN - 1)) begin
                cs_n  <= 1'b1;
                done  <= 1'b1;
                state <= S_DONE;
              end else begin
                hcnt  <= hcnt + 1'b1;
                go    <= 1'b1;
                state <= S_STREAM;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_boot_probe.sv
`timescale 1ns/1ps
// Top: probes boot memory width and streams the first header bytes.
module spi_boot_probe
  import spi_probe_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int HDR_LEN = 10,
  parameter int GAP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              start,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso,
  output logic [2:0]        mem_type,
  output logic              hdr_valid,
  input  logic              hdr_ready,
  output logic [BYTE_W-1:0] hdr_data,
  output logic              done,
  output logic              error
);
  logic              go;
  logic              eng_done;
  logic              load;
  logic              accept;
  logic [BYTE_W-1:0] tx;
  logic [BYTE_W-1:0] rx;
  mem_kind_e         kind;

  assign mem_type = kind;

  spi_byte_engine #(.DIV_W(DIV_W)) i_engine (
    .clk(clk), .rst_n(rst_n), .div(clk_div), .go(go), .tx(tx), .miso(miso),
    .sck(sck), .mosi(mosi), .done(eng_done), .rx(rx)
  );

  spi_probe_seq #(.HDR_LEN(HDR_LEN), .GAP_CYC(GAP_CYC)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .eng_done(eng_done),
    .eng_rx(rx), .accept(accept), .go(go), .tx(tx), .cs_n(cs_n),
    .load(load), .kind(kind), .done(done), .error(error)
  );

  hdr_out_reg i_out (
    .clk(clk), .rst_n(rst_n), .load(load), .din(rx), .ready(hdr_ready),
    .valid(hdr_valid), .data(hdr_data), .accept(accept)
  );
endmodule

// File: rtl/spi_boot_probe_chk.sv
`timescale 1ns/1ps
module spi_boot_probe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic       cs_n,
  input logic [2:0] mem_type,
  input logic       hdr_valid,
  input logic       hdr_ready,
  input logic [7:0] hdr_data,
  input logic       done,
  input logic       error
);
  AST_SCK_IDLE_OFF_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck); // R2
  AST_HOLD_STALLED_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !hdr_ready |=> hdr_valid && $stable(hdr_data)); // R8
  AST_NO_SCK_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !hdr_ready |=> $stable(sck)); // R8
  AST_STREAM_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> !cs_n); // R7
  AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (mem_type == 3'd0) && cs_n && !done && !hdr_valid); // R6
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n && !hdr_valid && (mem_type != 3'd0)); // R9
endmodule

bind spi_boot_probe spi_boot_probe_chk i_chk (.*);

// File: tb/test_spi_boot_probe.sv
`timescale 1ns/1ps
module test_spi_boot_probe;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] clk_div = 8'd2;
  logic       start = 1'b0;
  logic       sck, cs_n, mosi;
  logic       miso = 1'b1;
  logic [2:0] mem_type;
  logic       hdr_valid;
  logic       hdr_ready = 1'b1;
  logic [7:0] hdr_data;
  logic       done, error;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_boot_probe i_spi_boot_probe (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .start(start), .sck(sck),
    .cs_n(cs_n), .mosi(mosi), .miso(miso), .mem_type(mem_type),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data),
    .done(done), .error(error)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  int         kind_m = 0;          // 0 none, 1..3 address bytes, 4 paged flash
  logic [7:0] mem [16];
  int         rbits = 0, kbytes = 0, frames = 0, last_bytes = 0;
  logic [7:0] rsh = 0, op = 0, osh = 8'hFF, last_op = 0;
  int         cyc = 0, t_rise = 0, hp_min = 0, hp_max = 0;

  function automatic logic [7:0] reply(int k);
    if (kind_m >= 1 && kind_m <= 3) begin
      if (op == 8'h03 && k >= 1 + kind_m && k - 1 - kind_m < 16) return mem[k-1-kind_m];
    end else if (kind_m == 4) begin
      if (op == 8'hD7 && k >= 1) return 8'hAC;
      if (op == 8'h0B && k >= 5 && k - 5 < 16) return mem[k-5];
    end
    return 8'hFF;
  endfunction

  always @(negedge cs_n) begin
    frames++; rbits = 0; kbytes = 0; osh = 8'hFF; miso = 1'b1;
  end
  always @(posedge cs_n) miso = 1'b1;

  always @(posedge sck) if (!cs_n) begin
    rsh = {rsh[6:0], mosi};
    rbits++;
    if (rbits % 8 == 0) begin
      kbytes++;
      if (kbytes == 1) op = rsh;
      last_op = op;
      last_bytes = kbytes;
    end
    t_rise = cyc;
  end

  always @(negedge sck) if (!cs_n) begin
    if (cyc - t_rise < hp_min) hp_min = cyc - t_rise;
    if (cyc - t_rise > hp_max) hp_max = cyc - t_rise;
    if (rbits % 8 == 0) osh = reply(kbytes);
    else                osh = {osh[6:0], 1'b1};
    miso = osh[7];
  end

  // ---------------- scoreboard monitor ----------------
  logic [7:0] exp_q [$];
  bit         bp = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit         stall_prev = 0;
  logic       sck_prev = 0;
  int         stall_err = 0;

  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    hdr_ready = bp ? lfsr[0] : 1'b1;
    if (stall_prev && sck !== sck_prev) stall_err++;
    if (hdr_valid && hdr_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R7 unexpected header byte", hdr_data, -1);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(hdr_data == e, "R7 header byte value", hdr_data, e);
      end
    end
    stall_prev = hdr_valid && !hdr_ready;
    sck_prev = sck;
  end

  // ---------------- driver ----------------
  task automatic run(int kind, int dv, bit backp, bit stray_start, int exp_frames,
                     int exp_op, int exp_bytes, bit exp_err, string tag);
    int eff;
    eff = (dv == 0) ? 1 : dv;
    for (int i = 0; i < 16; i++)
      mem[i] = (i == 0) ? 8'h40 : 8'(i * 29 + kind * 7 + 3);
    exp_q.delete();
    if (!exp_err) for (int i = 0; i < 10; i++) exp_q.push_back(mem[i]);
    kind_m = kind; clk_div = 8'(dv); bp = backp;
    frames = 0; last_bytes = 0; hp_min = 1000; hp_max = 0; stall_err = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (stray_start) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!(done || error)) @(negedge clk);
    repeat (4) @(negedge clk);
    check(mem_type == 3'(exp_err ? 0 : kind), {tag, " R4 mem_type"}, mem_type, exp_err ? 0 : kind);
    check(frames == exp_frames, {tag, " R3 frame count"}, frames, exp_frames);
    check(last_op == 8'(exp_op), {tag, " R7 last frame opcode"}, last_op, exp_op);
    check(last_bytes == exp_bytes, {tag, " R9 last frame bytes"}, last_bytes, exp_bytes);
    check(exp_q.size() == 0, {tag, " R7 header bytes left"}, exp_q.size(), 0);
    check(hp_min == eff && hp_max == eff, {tag, " R2 sck half period"}, hp_max, eff);
    check(cs_n == 1'b1 && sck == 1'b0, {tag, " R2 bus idle at end"}, {cs_n, sck}, 2);
    check(done == !exp_err, {tag, " R9 done flag"}, done, !exp_err);
    check(error == exp_err, {tag, " R6 error flag"}, error, exp_err);
    if (backp) check(stall_err == 0, {tag, " R8 sck moved while stalled"}, stall_err, 0);
  endtask

  initial begin
    #600000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n == 1'b1, "R1 reset cs_n", cs_n, 1);
    check(sck == 1'b0, "R1 reset sck", sck, 0);
    check(hdr_valid == 1'b0 && done == 1'b0 && error == 1'b0, "R1 reset flags",
          {hdr_valid, done, error}, 0);
    check(mem_type == 3'd0, "R1 reset mem_type", mem_type, 0);
    // R3 R4 R10: 16-bit memory, stray start during the run
    run(2, 2, 0, 1, 3, 8'h03, 13, 0, "a16");
    // R8: 8-bit memory with back-pressure
    run(1, 1, 1, 0, 2, 8'h03, 12, 0, "a8");
    // 24-bit memory, back-pressure, slower clock
    run(3, 3, 1, 0, 4, 8'h03, 14, 0, "a24");
    // R5: paged flash, divisor 0 acts as 1
    run(4, 0, 0, 0, 5, 8'h0B, 15, 0, "paged");
    // R6: nothing answers
    run(0, 2, 0, 0, 4, 8'hD7, 2, 1, "none");
    check(hdr_valid == 1'b0, "R6 no stream after error", hdr_valid, 0);
    // R10: restart after error
    run(1, 4, 0, 0, 2, 8'h03, 12, 0, "restart");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule